// File: doc/BRIEF.md
# ROM Emulation Memory Controller

This block stands in for a read-only code memory socket. A target processor sees an ordinary read-only memory: it drives a select, an output enable and a word address, and it gets back the stored word one clock later. Behind that port the storage is RAM. A local controller writes words through its own port at any time, whether to load a whole code image or to swap a single word for a trap instruction, and the target does not stop while this happens.

The target has no write strobe. It can still send bytes to the host through a mailbox: a window at the top of the emulated space, where a coded pair of reads carries one byte. The target first reads the window's unlock word, at window offset 0x000. Its next read, at window offset 0x100 + b, delivers byte b. The decoder pushes each such byte into a 16-entry FIFO. A not-empty flag wakes the controller, which pops the bytes and forwards them the way a serial port would.

The decoder is a two-state machine. In state IDLE, a read at the unlock offset takes the transition ARM to state ARMED. Any other read leaves the machine in IDLE. In state ARMED, a read at a data offset takes the transition DELIVER: the byte is pushed and the machine returns to IDLE. A read at the unlock offset takes the transition REARM and the machine stays in ARMED. Any other read takes the transition ABORT back to IDLE. A cycle with no target read never changes the state.

Top module: `rom_emu_ctrl`

## Requirements
- R1: After reset, tgt_data is 0 and mbx_irq is 0.
- R2: A cycle with tgt_sel and tgt_oe both high is a target read. The word at tgt_addr appears on tgt_data after the next clock edge. In cycles without a read, tgt_data holds its value.
- R3: A control write (ctl_we high) stores ctl_wdata at ctl_addr at the clock edge. Target reads of any address carry on at the same time, and later target reads of that address return the new word.
- R4: When a control write and a target read hit the same address in one cycle, the target receives the old word. The write still takes effect in that cycle, so the next read of that address returns the new word.
- R5: The mailbox window starts at word address WIN_BASE (default 0x600) and spans 512 words. A target read at window offset 0x100+b pushes byte b, where b is offset bits [7:0], into the FIFO. This happens only when the previous target read was at window offset 0x000.
- R6: A data-offset read whose previous target read was not the unlock read pushes nothing. This includes the case where another address was read in between. Cycles without a target read do not count as reads, so a data read still counts after such gaps.
- R7: Consecutive unlock reads keep the decoder armed. After a byte is delivered, a second data read with no new unlock read pushes nothing.
- R8: The FIFO holds 16 bytes and returns them in arrival order. A byte delivered while the FIFO is full is dropped.
- R9: mbx_irq is high exactly when the FIFO is not empty, and mbx_byte shows the oldest byte. When mbx_pop is high, the edge removes that byte. A pop while the FIFO is empty has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tgt_sel | input | 1 | Target chip select, active high |
| tgt_oe | input | 1 | Target output enable, active high |
| tgt_addr | input | 11 | Target word address |
| tgt_data | output | 16 | Read data, valid one cycle after the read |
| ctl_we | input | 1 | Control-side word write strobe |
| ctl_addr | input | 11 | Control-side word address |
| ctl_wdata | input | 16 | Control-side write data |
| mbx_pop | input | 1 | Remove the oldest mailbox byte |
| mbx_byte | output | 8 | Oldest mailbox byte |
| mbx_irq | output | 1 | Mailbox not empty (wake-up) |

## Verification
Target read data is due one clock edge after the read cycle. The bench drives each read, waits for exactly one edge, and then compares tgt_data against a shadow copy of memory. That shadow copy is taken before the same cycle's control write is applied, which is what R4 requires. A delivered byte reaches mbx_irq and mbx_byte on the same edge that samples the data read. A pop shows its effect after its own edge. For these reasons every mailbox check comes one edge after the operation, and it is compared against a queue model of the decoder and FIFO held in the bench. Stimulus is a fixed-seed random mix of reads, collisions and mailbox sequences, plus directed cases for gaps, aborts, re-arming and overflow.

// File: rtl/rom_emu_pkg.sv
package rom_emu_pkg;
    typedef enum logic [0:0] {
        DEC_IDLE  = 1'b0,
        DEC_ARMED = 1'b1
    } dec_state_t;
endpackage

// File: rtl/emu_ram.sv
module emu_ram #(
    parameter int AW = 11,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    input  logic          we,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] store [DEPTH];

    // Write port; the read below samples the pre-edge contents (old data on collision)
    always_ff @(posedge clk) begin
        if (we) store[wr_addr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)  rd_data <= '0;
        else if (rd) rd_data <= store[rd_addr];
    end

    // R2: data only moves when a read was requested
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> $stable(rd_data));
endmodule

// File: rtl/mbx_decoder.sv
module mbx_decoder
    import rom_emu_pkg::*;
#(
    parameter int AW       = 11,
    parameter int WIN_W    = 9,
    parameter int WIN_BASE = 'h600
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd,
    input  logic [AW-1:0] addr,
    output logic          push,
    output logic [7:0]    push_byte
);
    localparam logic [AW-WIN_W-1:0] WIN_TAG = AW'(WIN_BASE) >> WIN_W;

    dec_state_t state, state_nx;
    logic in_win, is_unlock, is_data;
    logic [WIN_W-1:0] off;

    assign off       = addr[WIN_W-1:0];
    assign in_win    = addr[AW-1:WIN_W] == WIN_TAG;
    assign is_unlock = in_win && (off == '0);
    assign is_data   = in_win && (off[WIN_W-1:8] == (WIN_W-8)'(1));

    always_ff @(posedge clk) begin
        if (!rst_n) state <= DEC_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx  = state;
        push      = 1'b0;
        push_byte = off[7:0];
        if (rd) begin
            unique case (state)
                DEC_IDLE: begin
                    if (is_unlock) state_nx = DEC_ARMED;      // ARM
                end
                DEC_ARMED: begin
                    if (is_data) begin                        // DELIVER
                        push     = 1'b1;
                        state_nx = DEC_IDLE;
                    end else if (is_unlock) begin             // REARM
                        state_nx = DEC_ARMED;
                    end else begin                            // ABORT
                        state_nx = DEC_IDLE;
                    end
                end
                default: state_nx = DEC_IDLE;
            endcase
        end
    end

    // R6: idle cycles do not disarm
    a_r6_armed_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state == DEC_ARMED && !rd) |=> state == DEC_ARMED);
    // R7: a delivery consumes the arming
    a_r7_push_disarms: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> state == DEC_IDLE);
endmodule

// File: rtl/mbx_fifo.sv
module mbx_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         not_empty
);
    localparam int PW = $clog2(DEPTH);

    logic [W-1:0]  slots [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [PW:0]   cnt;
    logic do_push, do_pop;

    assign do_pop    = pop && (cnt != '0);
    assign do_push   = push && (cnt != (PW+1)'(DEPTH));
    assign dout      = slots[rp];
    assign not_empty = cnt != '0;

    always_ff @(posedge clk) begin
        if (do_push) slots[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= wp + 1'b1;
            if (do_pop)  rp <= rp + 1'b1;
            cnt <= cnt + (PW+1)'(do_push) - (PW+1)'(do_pop);
        end
    end

    // R8: occupancy bounded; a push into a full FIFO is dropped
    a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= (PW+1)'(DEPTH));
    a_r8_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == (PW+1)'(DEPTH) && !pop) |=> cnt == (PW+1)'(DEPTH));
    // R9: popping an empty FIFO changes nothing
    a_r9_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0 && !push) |=> cnt == '0);
endmodule

// File: rtl/rom_emu_ctrl.sv
module rom_emu_ctrl #(
    parameter int AW       = 11,
    parameter int DW       = 16,
    parameter int WIN_W    = 9,
    parameter int WIN_BASE = 'h600,
    parameter int FDEPTH   = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tgt_sel,
    input  logic          tgt_oe,
    input  logic [AW-1:0] tgt_addr,
    output logic [DW-1:0] tgt_data,
    input  logic          ctl_we,
    input  logic [AW-1:0] ctl_addr,
    input  logic [DW-1:0] ctl_wdata,
    input  logic          mbx_pop,
    output logic [7:0]    mbx_byte,
    output logic          mbx_irq
);
    logic       rd, push;
    logic [7:0] push_byte;

    assign rd = tgt_sel && tgt_oe;

    emu_ram #(.AW(AW), .DW(DW)) i_ram (
        .clk(clk), .rst_n(rst_n),
        .rd(rd), .rd_addr(tgt_addr), .rd_data(tgt_data),
        .we(ctl_we), .wr_addr(ctl_addr), .wr_data(ctl_wdata)
    );

    mbx_decoder #(.AW(AW), .WIN_W(WIN_W), .WIN_BASE(WIN_BASE)) i_dec (
        .clk(clk), .rst_n(rst_n), .rd(rd), .addr(tgt_addr),
        .push(push), .push_byte(push_byte)
    );

    mbx_fifo #(.DEPTH(FDEPTH), .W(8)) i_fifo (
        .clk(clk), .rst_n(rst_n), .push(push), .din(push_byte),
        .pop(mbx_pop), .dout(mbx_byte), .not_empty(mbx_irq)
    );

    // R5: the wake-up only rises on a cycle that carried a target read
    a_r5_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mbx_irq) |-> $past(rd));
endmodule

// File: tb/test_rom_emu_ctrl.sv
module test_rom_emu_ctrl;
    localparam int AW = 11, DW = 16, WIN_BASE = 'h600;

    logic clk = 0, rst_n = 0;
    logic tgt_sel = 0, tgt_oe = 0, ctl_we = 0, mbx_pop = 0;
    logic [AW-1:0] tgt_addr = '0, ctl_addr = '0;
    logic [DW-1:0] ctl_wdata = '0, tgt_data;
    logic [7:0] mbx_byte;
    logic mbx_irq;

    int checks = 0, errors = 0;
    logic [DW-1:0] shadow [1<<AW];
    int q[$];
    bit armed = 0;
    logic [DW-1:0] last_data = '0;

    always #5 clk = ~clk;

    rom_emu_ctrl i_rom_emu_ctrl (
        .clk(clk), .rst_n(rst_n), .tgt_sel(tgt_sel), .tgt_oe(tgt_oe),
        .tgt_addr(tgt_addr), .tgt_data(tgt_data), .ctl_we(ctl_we),
        .ctl_addr(ctl_addr), .ctl_wdata(ctl_wdata), .mbx_pop(mbx_pop),
        .mbx_byte(mbx_byte), .mbx_irq(mbx_irq)
    );

    function automatic logic [DW-1:0] pat(int a);
        return DW'((a * 40503 + 17) ^ (a << 5));
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // model of the decoder for one target read
    task automatic model_read(int a);
        int off;
        off = a - WIN_BASE;
        if (a >= WIN_BASE && a < WIN_BASE + 512) begin
            if (armed && off >= 'h100 && off < 'h200 && q.size() < 16) q.push_back(off & 'hff);
            armed = (off == 0);
        end else armed = 0;
    endtask

    task automatic trd(int a);
        tgt_sel = 1; tgt_oe = 1; tgt_addr = AW'(a);
        step();
        tgt_sel = 0; tgt_oe = 0;
        model_read(a);
    endtask

    task automatic pop1();
        mbx_pop = 1;
        step();
        mbx_pop = 0;
        if (q.size() != 0) void'(q.pop_front());
    endtask

    task automatic chk_mbx(string req);
        chk({req, " irq"}, int'(mbx_irq), int'(q.size() != 0));
        if (q.size() != 0) chk({req, " byte"}, int'(mbx_byte), q[0]);
    endtask

    initial begin
        #(200000 * 10);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed1));
        repeat (3) step();
        rst_n = 1;
        step();
        chk("R1 data", int'(tgt_data), 0);
        chk("R1 irq", int'(mbx_irq), 0);

        // R3: load image through the control port
        for (int a = 0; a < (1 << AW); a++) begin
            ctl_we = 1; ctl_addr = AW'(a); ctl_wdata = pat(a);
            step();
            shadow[a] = pat(a);
        end
        ctl_we = 0;
        trd(3);
        chk("R3 load", int'(tgt_data), int'(shadow[3]));
        last_data = tgt_data;

        // R4: directed collision
        tgt_sel = 1; tgt_oe = 1; tgt_addr = 11'h0a5;
        ctl_we = 1; ctl_addr = 11'h0a5; ctl_wdata = 16'hdead;
        step();
        tgt_sel = 0; tgt_oe = 0; ctl_we = 0;
        chk("R4 old data", int'(tgt_data), int'(shadow['h0a5]));
        shadow['h0a5] = 16'hdead;
        trd('h0a5);
        chk("R4 new data", int'(tgt_data), 'hdead);
        last_data = tgt_data;

        // R2/R3/R4: random reads with concurrent patching, outside the window
        for (int i = 0; i < 3000; i++) begin
            int ra, wa;
            bit r, w;
            logic [DW-1:0] exp, wd;
            r  = ($urandom % 4) != 0;
            w  = ($urandom % 2) != 0;
            ra = $urandom % WIN_BASE;
            wa = (($urandom % 4) == 0) ? ra : ($urandom % WIN_BASE);
            wd = DW'($urandom);
            tgt_sel = r; tgt_oe = r ? 1'b1 : 1'($urandom % 2); tgt_addr = AW'(ra);
            ctl_we = w; ctl_addr = AW'(wa); ctl_wdata = wd;
            exp = r ? shadow[ra] : last_data;
            step();
            tgt_sel = 0; tgt_oe = 0; ctl_we = 0;
            if (w) shadow[wa] = wd;
            if (r) armed = 0;
            chk(r ? "R2/R4 read" : "R2 hold", int'(tgt_data), int'(exp));
            last_data = tgt_data;
        end

        // R5: basic delivery
        trd(WIN_BASE); trd(WIN_BASE + 'h141);
        chk_mbx("R5 deliver");
        chk("R5 byte", int'(mbx_byte), 'h41);
        pop1(); chk_mbx("R9 pop");

        // R6: data read without unlock, and unlock aborted by another read
        trd(WIN_BASE + 'h122); chk_mbx("R6 no unlock");
        trd(WIN_BASE); trd(5); trd(WIN_BASE + 'h133); chk_mbx("R6 aborted");
        chk("R6 irq", int'(mbx_irq), 0);
        // R6: idle gaps keep arming
        trd(WIN_BASE); repeat (4) step(); trd(WIN_BASE + 'h1c7);
        chk_mbx("R6 gap");
        chk("R6 gap byte", int'(mbx_byte), 'hc7);
        pop1();

        // R7: rearm, then double data read
        trd(WIN_BASE); trd(WIN_BASE); trd(WIN_BASE + 'h1fe);
        trd(WIN_BASE + 'h1ab);
        chk_mbx("R7 rearm");
        chk("R7 one byte", int'(mbx_byte), 'hfe);
        pop1(); chk("R7 second ignored", int'(mbx_irq), 0);

        // R8: overflow drops, order preserved
        for (int b = 0; b < 20; b++) begin
            trd(WIN_BASE); trd(WIN_BASE + 'h100 + b);
        end
        for (int b = 0; b < 16; b++) begin
            chk("R8 order", int'(mbx_byte), b);
            pop1();
        end
        chk("R8 drop", int'(mbx_irq), 0);
        // R9: pop on empty
        pop1(); chk_mbx("R9 empty pop");
        trd(WIN_BASE); trd(WIN_BASE + 'h1aa);
        chk("R9 after empty pop", int'(mbx_byte), 'haa);
        pop1();

        // R5-R9 random mailbox traffic
        for (int i = 0; i < 2000; i++) begin
            int k;
            k = $urandom % 8;
            if (k < 3)      trd(WIN_BASE);
            else if (k < 6) trd(WIN_BASE + 'h100 + ($urandom % 256));
            else if (k < 7) pop1();
            else            trd($urandom % (1 << AW));
            chk_mbx("R8/R9 random");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule